// File: doc/BRIEF.md
# Bit-Sliced GF(2) Matrix Multiplier

This block multiplies many small binary vectors by one programmable square bit-matrix over GF(2). Each product term is an AND and each sum is an XOR. The operands arrive in bit-slice layout: the operand is a set of slice words, and slice word `i` carries bit `i` of every vector. With the default parameters, one operand bundle holds eight 32-bit slice words, so a single multiply transforms 32 independent 8-bit vectors at once. Because of this layout, each output slice word is simply the XOR of the input slice words that one matrix row selects.

The matrix is written one row per cycle through a row-write port. The operand bundle enters through a valid/ready port. The result leaves one cycle later on a valid/ready port, in the same slice layout. Writing the matrix is refused while a result is held. This guarantees that every multiply sees a complete and consistent matrix. A parameter selects one of two equivalent forms of the XOR network:
- slice-major: whole words are masked and then XORed;
- lane-major: a parity is taken for each lane.

Top module: `bsm_gf2_matmul`

## Requirements
- R1: Slice word `j` of the result (bits `j*LANES +: LANES`) equals the XOR of every operand slice word `i` (bits `i*LANES +: LANES`) for which bit `i` of matrix row `j` is 1. A row of all zeros gives a zero slice word.
- R2: After reset, `res_valid` is low and the matrix is the identity (row `r` has only bit `r` set). An accepted bundle therefore comes back unchanged until rows are written.
- R3: A bundle is accepted on a clock edge where `op_valid` and `op_ready` are both high. `res_valid` is high in the cycle after that edge, carrying that bundle's product.
- R4: `op_ready` is high exactly when no result is held or `res_ready` is high. It is therefore low while a result waits with `res_ready` low.
- R5: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_slices` does not change.
- R6: A row write loads `mat_wr_bits` into the row given by `mat_wr_row` on an edge where `mat_wr_en` and `mat_wr_rdy` are both high. Bit `i` of the row selects operand slice `i`. The new row is used by bundles accepted on later edges. A bundle accepted on the same edge as the write uses the earlier contents.
- R7: `mat_wr_rdy` is low exactly while `res_valid` is high. A write attempted while `mat_wr_rdy` is low leaves the matrix unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mat_wr_en | input | 1 | Row write request |
| mat_wr_row | input | 3 | Index of the row to write |
| mat_wr_bits | input | 8 | New row contents; bit i selects operand slice i |
| mat_wr_rdy | output | 1 | Row write may be taken this cycle |
| op_valid | input | 1 | Operand bundle present |
| op_ready | output | 1 | Operand bundle can be accepted |
| op_slices | input | 256 | Eight 32-bit operand slice words, slice i at bits i*32 +: 32 |
| res_valid | output | 1 | Result bundle present |
| res_ready | input | 1 | Downstream takes the result |
| res_slices | output | 256 | Eight 32-bit result slice words, same layout |

## Verification
The bench builds two copies of the block with the default sizes (32 lanes, 8×8 matrix). One copy uses the slice-major XOR network and the other the lane-major network. Both are fed identical stimulus, so one run compares both variants against the same behavioural model. That model un-slices every bundle, multiplies each of the 32 vectors separately and re-slices the result.

Several kinds of stimulus are applied:
- periods of heavy backpressure, which hold results for many cycles;
- row writes that collide with operand acceptance or land while a result is held;
- all-zero rows and all-zero operand bundles.

Together these reach the matrix snapshot rule and the hold behaviour.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

   // Structural form chosen for the GF(2) XOR network.
   typedef enum logic {
      XOR_SLICE_MAJOR = 1'b0,
      XOR_LANE_MAJOR  = 1'b1
   } xor_form_e;

endpackage

// File: rtl/bsm_matrix_store.sv
module bsm_matrix_store #(
   parameter int DIM   = 8,
   localparam int ROW_W = (DIM > 1) ? $clog2(DIM) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 busy,
   input  logic                 wr_en,
   input  logic [ROW_W-1:0]     wr_row,
   input  logic [DIM-1:0]       wr_bits,
   output logic                 wr_ready,
   output logic [DIM*DIM-1:0]   rows_flat
);

   logic [DIM-1:0] rows_q [DIM];
   logic           wr_take;
   logic           row_in_range;

   assign wr_ready     = ~busy;
   assign row_in_range = (32'(wr_row) < DIM);
   assign wr_take      = wr_en & wr_ready & row_in_range;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < DIM; r++) begin
            rows_q[r] <= DIM'(1) << r;
         end
      end else if (wr_take) begin
         rows_q[wr_row] <= wr_bits;
      end
   end

   for (genvar g = 0; g < DIM; g++) begin : g_flat
      assign rows_flat[g*DIM +: DIM] = rows_q[g];
   end

   // Matrix may not move while a product is outstanding.
   assert_write_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(rows_flat))
      else $error("matrix changed while result held");

endmodule

// File: rtl/bsm_xor_plane.sv
module bsm_xor_plane
   import bsm_pkg::*;
#(
   parameter int        LANES = 32,
   parameter int        DIM   = 8,
   parameter xor_form_e FORM  = XOR_SLICE_MAJOR,
   localparam int       W     = LANES * DIM
) (
   input  logic [W-1:0]       slices_in,
   input  logic [DIM*DIM-1:0] rows_flat,
   output logic [W-1:0]       slices_out
);

   if (FORM == XOR_SLICE_MAJOR) begin : g_slice_major
      // Each output word: masked XOR of whole input words.
      for (genvar j = 0; j < DIM; j++) begin : g_out
         logic [LANES-1:0] acc;
         always_comb begin
            acc = '0;
            for (int i = 0; i < DIM; i++) begin
               acc ^= slices_in[i*LANES +: LANES] & {LANES{rows_flat[j*DIM + i]}};
            end
         end
         assign slices_out[j*LANES +: LANES] = acc;
      end
   end else begin : g_lane_major
      // Each lane: gather its vector, parity against every row.
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         logic [DIM-1:0] vec;
         for (genvar i = 0; i < DIM; i++) begin : g_gather
            assign vec[i] = slices_in[i*LANES + k];
         end
         for (genvar j = 0; j < DIM; j++) begin : g_row
            assign slices_out[j*LANES + k] = ^(vec & rows_flat[j*DIM +: DIM]);
         end
      end
   end

endmodule

// File: rtl/bsm_result_stage.sv
module bsm_result_stage #(
   parameter int W = 256
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);

   logic         valid_q;
   logic [W-1:0] data_q;
   logic         take;

   assign in_ready  = ~valid_q | out_ready;
   assign take      = in_valid & in_ready;
   assign out_valid = valid_q;
   assign out_data  = data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
      end else if (in_ready) begin
         valid_q <= in_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (take) begin
         data_q <= in_data;
      end
   end

   assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid)
      else $error("accepted bundle did not produce a result");

   assert_backpressure_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready)
      else $error("operand taken while result stalled");

   assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
      else $error("held result changed");

endmodule

// File: rtl/bsm_gf2_matmul.sv
module bsm_gf2_matmul
   import bsm_pkg::*;
#(
   parameter int        LANES = 32,
   parameter int        DIM   = 8,
   parameter xor_form_e FORM  = XOR_SLICE_MAJOR,
   localparam int       W     = LANES * DIM,
   localparam int       ROW_W = (DIM > 1) ? $clog2(DIM) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mat_wr_en,
   input  logic [ROW_W-1:0] mat_wr_row,
   input  logic [DIM-1:0]   mat_wr_bits,
   output logic             mat_wr_rdy,
   input  logic             op_valid,
   output logic             op_ready,
   input  logic [W-1:0]     op_slices,
   output logic             res_valid,
   input  logic             res_ready,
   output logic [W-1:0]     res_slices
);

   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (DIM < 2 || DIM > 64) begin : g_bad_dim
      $error("DIM must lie in 2..64");
   end

   logic [DIM*DIM-1:0] rows_flat;
   logic [W-1:0]       product;

   bsm_matrix_store #(.DIM(DIM)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (res_valid),
      .wr_en     (mat_wr_en),
      .wr_row    (mat_wr_row),
      .wr_bits   (mat_wr_bits),
      .wr_ready  (mat_wr_rdy),
      .rows_flat (rows_flat)
   );

   bsm_xor_plane #(.LANES(LANES), .DIM(DIM), .FORM(FORM)) u_plane (
      .slices_in  (op_slices),
      .rows_flat  (rows_flat),
      .slices_out (product)
   );

   bsm_result_stage #(.W(W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (op_valid),
      .in_ready  (op_ready),
      .in_data   (product),
      .out_valid (res_valid),
      .out_ready (res_ready),
      .out_data  (res_slices)
   );

   // Zero operands stay zero whatever the matrix holds.
   assert_zero_maps_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_ready && op_slices == '0) |=> (res_slices == '0))
      else $error("zero bundle produced nonzero result");

   assert_write_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !mat_wr_rdy)
      else $error("row write offered while result held");

endmodule

// File: tb/bsm_gf2_matmul_tb.sv
`timescale 1ns/1ps
module bsm_gf2_matmul_tb;
   import bsm_pkg::*;

   localparam int L = 32;
   localparam int N = 8;
   localparam int W = L * N;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         mat_wr_en;
   logic [2:0]   mat_wr_row;
   logic [7:0]   mat_wr_bits;
   logic         op_valid;
   logic [W-1:0] op_slices;
   logic         res_ready;

   logic         mat_wr_rdy, op_ready, res_valid;
   logic [W-1:0] res_slices;
   logic         mat_wr_rdy_b, op_ready_b, res_valid_b;
   logic [W-1:0] res_slices_b;

   int compared   = 0;
   int mismatched = 0;

   logic [7:0]   mdl [N];
   logic [W-1:0] q [$];
   logic         held_prev;
   logic [W-1:0] data_prev;

   always #2 clk = ~clk;

   bsm_gf2_matmul #(.LANES(L), .DIM(N), .FORM(XOR_SLICE_MAJOR)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .mat_wr_en(mat_wr_en), .mat_wr_row(mat_wr_row), .mat_wr_bits(mat_wr_bits),
      .mat_wr_rdy(mat_wr_rdy),
      .op_valid(op_valid), .op_ready(op_ready), .op_slices(op_slices),
      .res_valid(res_valid), .res_ready(res_ready), .res_slices(res_slices)
   );

   bsm_gf2_matmul #(.LANES(L), .DIM(N), .FORM(XOR_LANE_MAJOR)) u_alt (
      .clk(clk), .rst_n(rst_n),
      .mat_wr_en(mat_wr_en), .mat_wr_row(mat_wr_row), .mat_wr_bits(mat_wr_bits),
      .mat_wr_rdy(mat_wr_rdy_b),
      .op_valid(op_valid), .op_ready(op_ready_b), .op_slices(op_slices),
      .res_valid(res_valid_b), .res_ready(res_ready), .res_slices(res_slices_b)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Un-slice, multiply each vector on its own, re-slice.
   function automatic logic [W-1:0] ref_product(input logic [W-1:0] s);
      logic [W-1:0] r;
      r = '0;
      for (int k = 0; k < L; k++) begin
         logic [7:0] v;
         logic [7:0] y;
         for (int i = 0; i < N; i++) v[i] = s[i*L + k];
         for (int j = 0; j < N; j++) begin
            int p;
            p = 0;
            for (int i = 0; i < N; i++) p += (mdl[j][i] & v[i]);
            y[j] = p[0];
         end
         for (int j = 0; j < N; j++) r[j*L + k] = y[j];
      end
      return r;
   endfunction

   function automatic logic [W-1:0] rnd_bundle();
      logic [W-1:0] b;
      for (int i = 0; i < N; i++) b[i*L +: L] = $urandom();
      return b;
   endfunction

   task automatic step(input logic ov, input logic [W-1:0] data, input logic rr,
                       input logic we, input logic [2:0] row, input logic [7:0] bits);
      @(negedge clk);
      op_valid = ov; op_slices = data; res_ready = rr;
      mat_wr_en = we; mat_wr_row = row; mat_wr_bits = bits;
      #1;
      chk("R3 res_valid vs outstanding", W'(res_valid), W'(q.size() != 0));
      chk("R4 op_ready", W'(op_ready), W'(!res_valid || rr));
      chk("R7 mat_wr_rdy", W'(mat_wr_rdy), W'(!res_valid));
      chk("R1 lane-major res_valid", W'(res_valid_b), W'(res_valid));
      if (res_valid && q.size() != 0) begin
         chk("R1/R6 product", res_slices, q[0]);
         chk("R1 lane-major product", res_slices_b, q[0]);
      end
      if (held_prev) chk("R5 held result stable", res_slices, data_prev);
      held_prev = res_valid && !rr;
      data_prev = res_slices;
      if (res_valid && rr && q.size() != 0) void'(q.pop_front());
      if (ov && op_ready) q.push_back(ref_product(data));
      if (we && mat_wr_rdy) mdl[row] = bits;
   endtask

   task automatic run_phase(input int cycles, input int p_op, input int p_rr,
                            input int p_wr, input bit zero_data);
      for (int c = 0; c < cycles; c++) begin
         logic [W-1:0] d;
         d = zero_data ? '0 : rnd_bundle();
         step(($urandom % 100) < p_op, d, ($urandom % 100) < p_rr,
              ($urandom % 100) < p_wr, 3'($urandom), 8'($urandom));
      end
   endtask

   initial begin
      rst_n = 1'b0; mat_wr_en = 0; mat_wr_row = 0; mat_wr_bits = 0;
      op_valid = 0; op_slices = '0; res_ready = 0;
      held_prev = 0; data_prev = '0;
      for (int r = 0; r < N; r++) mdl[r] = 8'(1) << r;
      repeat (3) @(negedge clk);
      #1;
      chk("R2 res_valid after reset", W'(res_valid), W'(0));
      chk("R7 write port open after reset", W'(mat_wr_rdy), W'(1));
      rst_n = 1'b1;
      // R2: identity matrix passes bundles through
      run_phase(40, 80, 100, 0, 0);
      // R6 same-edge write vs accept: write row 0 to zero while accepting
      step(1, rnd_bundle(), 1, 1, 3'd0, 8'h00);
      step(1, rnd_bundle(), 1, 0, 3'd0, 8'h00);
      // R1: zero rows and zero bundles
      for (int r = 0; r < N; r++) step(0, '0, 1, 1, 3'(r), 8'h00);
      run_phase(10, 90, 100, 0, 0);
      run_phase(10, 90, 100, 0, 1);
      // R6: mixed programming under moderate backpressure
      run_phase(600, 70, 50, 30, 0);
      // R5/R7: heavy backpressure with writes hammering a held result
      run_phase(600, 80, 10, 60, 0);
      run_phase(20, 0, 100, 0, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule